// File: doc/BRIEF.md
# Multi-format stereo serial audio receiver

This block takes stereo audio samples for a dual-channel 16-bit converter from a serial link and presents them as a pair of parallel words. A two-bit mode input picks one of three framings. In the two multiplexed framings one data line carries left and right words in turn, delimited by a word-select line, and a bit clock strobes each bit. In the simultaneous framing two data lines carry the left and right words side by side, and a latch-enable line marks the end of each pair. Words arrive MSB first.

The block runs on a fast system clock. The bit clock, the frame line (word select or latch enable) and both data lines pass through flop synchronisers, and edges are detected in the system clock domain. Every sample leaves the block as offset binary: two's-complement input has its sign bit inverted on the way out. A one-cycle strobe marks each update of the output pair.

The control is a four-state machine. ST_ALIGN waits for a frame boundary after reset or a mode change. ST_LEFT and ST_RIGHT collect the multiplexed left and right words. ST_SIMUL collects both words of the simultaneous framing. The transitions are as follows. A mode change sends any state to ST_ALIGN. ST_ALIGN goes to ST_LEFT on a bit-clock rise that sees word select low after it was high at the previous bit. ST_ALIGN goes to ST_SIMUL on a latch-enable rise in simultaneous mode. ST_LEFT goes to ST_RIGHT on a bit-clock rise with word select high, and the left word is held. ST_RIGHT goes to ST_LEFT on a bit-clock rise with word select low, and the pair is published. ST_SIMUL stays in ST_SIMUL and publishes on each latch-enable rise.

Top module: `serial_audio_rx`

## Requirements
- R1: During reset and at the first clock after it, both output words hold the mid-scale code 0x8000 and pair_valid is low.
- R2: With mode 00, bits are taken MSB first at bit-clock rises. Word select low marks a left bit and high marks a right bit. The offset-binary pair appears unchanged at the first bit-clock rise after word select falls.
- R3: With mode 01, the timing is as in R2, but input words are two's complement and are output with bit 15 inverted (offset binary).
- R4: Mode 11 behaves exactly as mode 00.
- R5: A word shorter than 16 bits is left-aligned, with zeros in the unreceived low bits.
- R6: A word longer than 16 bits keeps only its first 16 bits.
- R7: With mode 10, data_a_in carries left and data_b_in carries right, both offset binary and shifted together. The outputs update on the rising edge of frame_in (latch enable).
- R8: pair_valid is a single-cycle pulse, given once per output update. The output words change only in a cycle where pair_valid is high.
- R9: In the multiplexed modes data_b_in has no effect on the outputs.
- R10: After reset or any change of mode, nothing is published until a frame boundary has been seen. That is a falling word select in the multiplexed modes, or a first latch-enable rise in mode 10, which only aligns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Framing select: 00 mux offset binary, 01 mux two's complement, 10 simultaneous, 11 as 00 |
| sck_in | input | 1 | Serial bit clock |
| frame_in | input | 1 | Word select (mux modes) or latch enable (mode 10) |
| data_a_in | input | 1 | Serial data; both channels in mux modes, left in mode 10 |
| data_b_in | input | 1 | Right-channel serial data in mode 10, unused otherwise |
| left_out | output | 16 | Left sample, offset binary |
| right_out | output | 16 | Right sample, offset binary |
| pair_valid | output | 1 | One-cycle strobe on each output update |

## Verification
The bench aims at the word-boundary instants. If the update were placed on the rising word select, or on the edge before the first bit of the next left word, the outputs would show up one edge early and hold a half-formed right word. Short and long words check alignment and truncation: a design that right-aligned short words or kept the last 16 bits of long ones would give values scaled or shifted wrongly. Random traffic on the unused right data line, two's-complement input, the reserved mode and back-to-back mode changes expose sign-bit mistakes, leakage from the idle line, and spurious strobes sent before the framing is re-acquired.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        ST_ALIGN = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2,
        ST_SIMUL = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_CLEAR = 2'd1,
        SH_FIRST = 2'd2,
        SH_NEXT  = 2'd3
    } sh_op_e;

    localparam logic [1:0] MODE_MUX_OB = 2'b00;
    localparam logic [1:0] MODE_MUX_TC = 2'b01;
    localparam logic [1:0] MODE_SIMUL  = 2'b10;

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < STAGES; g++) pipe[g] <= '0;
        end else begin
            pipe[0] <= d_in;
            for (int g = 1; g < STAGES; g++) pipe[g] <= pipe[g-1];
        end
    end

    assign q_out = pipe[STAGES-1];

endmodule

// File: rtl/sarx_shift.sv
module sarx_shift
    import sarx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sh_op_e       op,
    input  logic         bit_in,
    output logic [W-1:0] word_out
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  word;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else begin
            unique case (op)
                SH_HOLD: ;
                SH_CLEAR: begin
                    word <= '0;
                    cnt  <= '0;
                end
                SH_FIRST: begin
                    word <= {bit_in, {(W-1){1'b0}}};
                    cnt  <= CW'(1);
                end
                SH_NEXT: begin
                    if (cnt < CW'(W)) begin
                        for (int i = 0; i < W; i++) begin
                            if (i == W - 1 - int'(cnt)) word[i] <= bit_in;
                        end
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign word_out = word;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic         sck_in,
    input  logic         frame_in,
    input  logic         data_a_in,
    input  logic         data_b_in,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out,
    output logic         pair_valid
);

    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    logic [3:0] raw_in, sync_in;
    logic       sck_s, frm_s, da_s, db_s;
    logic       sck_d, frm_d, ws_prev;
    logic [1:0] mode_q;
    logic       sck_rise, frm_rise, mode_chg;
    logic       is_sim, is_tc;

    rx_state_e  state, nxt;
    sh_op_e     op_a, op_b;
    logic       cap_left, publish;
    logic [W-1:0] word_a, word_b, hold_l;

    assign raw_in = {data_b_in, data_a_in, frame_in, sck_in};

    sarx_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .q_out (sync_in)
    );

    assign sck_s = sync_in[0];
    assign frm_s = sync_in[1];
    assign da_s  = sync_in[2];
    assign db_s  = sync_in[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            frm_d   <= 1'b0;
            ws_prev <= 1'b0;
            mode_q  <= MODE_MUX_OB;
        end else begin
            sck_d  <= sck_s;
            frm_d  <= frm_s;
            mode_q <= mode;
            if (sck_rise) ws_prev <= frm_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign frm_rise = frm_s & ~frm_d;
    assign mode_chg = (mode != mode_q);
    assign is_sim   = (mode == MODE_SIMUL);
    assign is_tc    = (mode == MODE_MUX_TC);

    sarx_shift #(.W(W)) u_shift_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_a),
        .bit_in   (da_s),
        .word_out (word_a)
    );

    sarx_shift #(.W(W)) u_shift_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op_b),
        .bit_in   (db_s),
        .word_out (word_b)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ALIGN;
        else        state <= nxt;
    end

    // Next state and per-cycle controls
    always_comb begin
        nxt      = state;
        op_a     = SH_HOLD;
        op_b     = SH_HOLD;
        cap_left = 1'b0;
        publish  = 1'b0;
        if (mode_chg) begin
            nxt  = ST_ALIGN;
            op_a = SH_CLEAR;
            op_b = SH_CLEAR;
        end else begin
            unique case (state)
                ST_ALIGN: begin
                    if (is_sim) begin
                        if (frm_rise) begin
                            nxt  = ST_SIMUL;
                            op_a = sck_rise ? SH_FIRST : SH_CLEAR;
                            op_b = sck_rise ? SH_FIRST : SH_CLEAR;
                        end
                    end else if (sck_rise && ws_prev && !frm_s) begin
                        nxt  = ST_LEFT;
                        op_a = SH_FIRST;
                    end
                end
                ST_LEFT: begin
                    if (sck_rise) begin
                        if (frm_s) begin
                            cap_left = 1'b1;
                            op_a     = SH_FIRST;
                            nxt      = ST_RIGHT;
                        end else begin
                            op_a = SH_NEXT;
                        end
                    end
                end
                ST_RIGHT: begin
                    if (sck_rise) begin
                        if (!frm_s) begin
                            publish = 1'b1;
                            op_a    = SH_FIRST;
                            nxt     = ST_LEFT;
                        end else begin
                            op_a = SH_NEXT;
                        end
                    end
                end
                ST_SIMUL: begin
                    if (frm_rise) begin
                        publish = 1'b1;
                        op_a    = sck_rise ? SH_FIRST : SH_CLEAR;
                        op_b    = sck_rise ? SH_FIRST : SH_CLEAR;
                    end else if (sck_rise) begin
                        op_a = SH_NEXT;
                        op_b = SH_NEXT;
                    end
                end
            endcase
        end
    end

    function automatic logic [W-1:0] to_ob(input logic [W-1:0] w, input logic tc);
        return tc ? {~w[W-1], w[W-2:0]} : w;
    endfunction

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_out   <= MID_CODE;
            right_out  <= MID_CODE;
            hold_l     <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= publish;
            if (cap_left) hold_l <= word_a;
            if (publish) begin
                if (is_sim) begin
                    left_out  <= word_a;
                    right_out <= word_b;
                end else begin
                    left_out  <= to_ob(hold_l, is_tc);
                    right_out <= to_ob(word_a, is_tc);
                end
            end
        end
    end

endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode,
    input logic [W-1:0] left_out,
    input logic [W-1:0] right_out,
    input logic         pair_valid
);

    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    // R1
    rst_mid_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (left_out == MID_CODE && right_out == MID_CODE && !pair_valid));

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R8
    left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_out != $past(left_out)) |-> pair_valid);

    // R8
    right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (right_out != $past(right_out)) |-> pair_valid);

    // R10
    mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |=> !pair_valid);

endmodule

bind serial_audio_rx sarx_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .left_out   (left_out),
    .right_out  (right_out),
    .pair_valid (pair_valid)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        sck_in = 1'b0;
    logic        frame_in = 1'b0;
    logic        data_a_in = 1'b0;
    logic        data_b_in = 1'b0;
    logic [15:0] left_out, right_out;
    logic        pair_valid;

    int nchk = 0;
    int nfail = 0;
    int vcount = 0;
    int vbase = 0;
    bit have_prev = 1'b0;
    logic [15:0] exp_l, exp_r;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_audio_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sck_in     (sck_in),
        .frame_in   (frame_in),
        .data_a_in  (data_a_in),
        .data_b_in  (data_b_in),
        .left_out   (left_out),
        .right_out  (right_out),
        .pair_valid (pair_valid)
    );

    always @(negedge clk) if (rst_n && pair_valid) vcount++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] expc(input logic [31:0] v, input int n, input bit tc);
        logic [31:0] t;
        logic [15:0] r;
        if (n >= 16) t = v >> (n - 16);
        else         t = v << (16 - n);
        r = t[15:0];
        if (tc) r[15] = ~r[15];
        return r;
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one multiplexed bit; data_b_in gets noise (R9)
    task automatic mux_bit(input logic ws, input logic d);
        frame_in  = ws;
        data_a_in = d;
        data_b_in = 1'($urandom);
        wclk(4);
        sck_in = 1'b1;
        wclk(4);
        sck_in = 1'b0;
    endtask

    // first left bit of a frame: publishes the previous pair (R2)
    task automatic mux_open(input logic d, input string req);
        mux_bit(1'b0, d);
        wclk(4);
        if (have_prev) begin
            chk({req, " left"}, 32'(left_out), 32'(exp_l));
            chk({req, " right"}, 32'(right_out), 32'(exp_r));
            chk("R8 one strobe", vcount - vbase, 1);
        end else begin
            chk("R10 no strobe before frame", vcount - vbase, 0);
        end
        vbase = vcount;
    endtask

    task automatic mux_frame(input logic [31:0] lv, input int ln,
                             input logic [31:0] rv, input int rn,
                             input bit tc, input string req);
        mux_open(lv[ln-1], req);
        for (int i = ln - 2; i >= 0; i--) mux_bit(1'b0, lv[i]);
        for (int i = rn - 1; i >= 0; i--) mux_bit(1'b1, rv[i]);
        exp_l = expc(lv, ln, tc);
        exp_r = expc(rv, rn, tc);
        have_prev = 1'b1;
    endtask

    task automatic mux_segment_start(input logic [1:0] m);
        mode = m;
        wclk(6);
        vbase = vcount;
        have_prev = 1'b0;
        mux_bit(1'b1, 1'b0);
    endtask

    task automatic sim_frame(input logic [31:0] lv, input logic [31:0] rv, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            data_a_in = lv[i];
            data_b_in = rv[i];
            wclk(4);
            sck_in = 1'b1;
            wclk(4);
            sck_in = 1'b0;
        end
        wclk(4);
        frame_in = 1'b1;
        wclk(6);
        frame_in = 1'b0;
        wclk(4);
        chk("R7 left", 32'(left_out), 32'(expc(lv, n, 1'b0)));
        chk("R7 right", 32'(right_out), 32'(expc(rv, n, 1'b0)));
        chk("R8 one strobe", vcount - vbase, 1);
        vbase = vcount;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        logic [31:0] a, b;
        void'($urandom(32'd4711));
        wclk(3);
        chk("R1 left reset", 32'(left_out), 32'h8000);
        chk("R1 right reset", 32'(right_out), 32'h8000);
        chk("R1 valid reset", 32'(pair_valid), 32'h0);
        rst_n = 1'b1;
        wclk(4);

        // R2 offset binary multiplexed, random
        mux_segment_start(2'b00);
        mux_frame(32'h0000_FFFF, 16, 32'h0000_0000, 16, 1'b0, "R2 corner");
        for (int k = 0; k < 6; k++) begin
            a = $urandom; b = $urandom;
            mux_frame(a, 16, b, 16, 1'b0, "R2 R9 mux ob");
        end
        mux_open(1'b0, "R2 last");

        // R3 two's complement
        mux_segment_start(2'b01);
        chk("R10 mode change held left", 32'(left_out), 32'(exp_l));
        mux_frame(32'h0000_7FFF, 16, 32'h0000_8000, 16, 1'b1, "R3 extremes");
        for (int k = 0; k < 6; k++) begin
            a = $urandom; b = $urandom;
            mux_frame(a, 16, b, 16, 1'b1, "R3 mux tc");
        end
        mux_open(1'b0, "R3 last");

        // R4 reserved mode
        mux_segment_start(2'b11);
        for (int k = 0; k < 3; k++) begin
            a = $urandom; b = $urandom;
            mux_frame(a, 16, b, 16, 1'b0, "R4 reserved");
        end
        mux_open(1'b0, "R4 last");

        // R5 short and R6 long words
        mux_segment_start(2'b00);
        mux_frame(32'h0000_00A5, 8, 32'h0000_0ABC, 12, 1'b0, "R5 short");
        mux_frame(32'h000F_1234, 20, 32'h00AB_CDEF, 24, 1'b0, "R6 long");
        mux_frame(32'h0000_0001, 1, 32'h0000_1F0F, 17, 1'b0, "R5 R6 mixed");
        mux_open(1'b0, "R5 R6 last");

        // R7 simultaneous
        mode = 2'b10;
        wclk(6);
        vbase = vcount;
        frame_in = 1'b1;
        wclk(6);
        frame_in = 1'b0;
        wclk(6);
        chk("R10 align latch no strobe", vcount - vbase, 0);
        sim_frame(32'h0000_8001, 32'h0000_7FFE, 16);
        for (int k = 0; k < 6; k++) begin
            a = $urandom; b = $urandom;
            sim_frame(a, b, 16);
        end
        sim_frame(32'h0000_02AB, 32'h0000_0155, 10);

        done = 1'b1;
        report();
    end

endmodule